// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer with Reload and Capture

This block is a 16-bit counter with one 16-bit reload/capture register. The two are shared across five operating modes. In plain auto-reload mode the counter reloads on overflow, and an external trigger can also force a reload. In capture mode a trigger edge copies the counter into the shared register. In up/down mode the direction comes from the trigger pin. In baud mode the counter generates receive and transmit rate ticks for a serial port. In clock-out mode a pin toggles once per overflow.

The counter advances on a clock-enable tick, or on a falling edge of a counter pin that is sampled on those ticks. Software configures the block through a byte-wide write port with eight addresses and reads it back through a combinational read port. The overflow and external flags are also driven straight to output pins, so an interrupt controller outside the block can observe them.

Top module: `tmr16_top`

## Requirements
- R1: After reset every register reads 0x00, and rxTick, txTick, clkOut, ovfFlag and extFlag are low.
- R2: While the run bit (control bit 0) is 1, the counter moves one step per count event. In timer mode (control bit 1 = 0) a count event is every cycle with tickEn high. In counter mode (bit 1 = 1) it is a synchronized falling edge of cntPin, sampled on tickEn cycles. While the run bit is 0, the counter and the reload/capture register keep their values.
- R3: In plain mode, when the counter is at 0xFFFF and an up-count event arrives, the counter loads the reload value and ovfFlag (control bit 4) sets.
- R4: In plain mode with the trigger enable (control bit 3) at 1, a synchronized falling edge of trigPin loads the reload value into the counter and sets extFlag (control bit 5). With the trigger enable at 0 the edge has no effect.
- R5: Capture mode is selected by control bit 2 = 1. In this mode a trigger falling edge, with the trigger enable at 1, copies the counter into the reload/capture register and sets extFlag. An overflow wraps the counter to 0x0000 and sets ovfFlag.
- R6: Up/down mode is selected by mode bit 0 = 1 while capture, baud and clock-out are all off. In this mode the synchronized level of trigPin sets the direction: 1 counts up, 0 counts down. A down step taken while the counter equals the reload value loads 0xFFFF. Every wrap in either direction sets ovfFlag and toggles extFlag. Trigger edges do not reload.
- R7: Baud mode is active when control bit 6 (receive select) or bit 7 (transmit select) is 1. In this mode the counter always reloads on overflow, whatever control bit 2 holds, and ovfFlag is not set. Each overflow gives a one-cycle pulse on rxTick and/or txTick, for whichever selects are 1.
- R8: Clock-out mode is selected by mode bit 1 = 1 while baud mode is off. In this mode the counter advances once every two tickEn cycles, reloads on overflow, and toggles clkOut on each overflow; ovfFlag is not set. The clkOut period is therefore 4 × (65536 − reload) tickEn cycles.
- R9: The register map is: 0 control, 1 mode, 2 counter low byte, 3 counter high byte, 4 reload low byte, 5 reload high byte. Writing the control register replaces the flag bits with the written data, so writing 0 clears a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Clock enable; timer-mode count event |
| cntPin | input | 1 | External count input (falling edges count) |
| trigPin | input | 1 | External trigger / direction input |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| ovfFlag | output | 1 | Overflow flag |
| extFlag | output | 1 | External-event flag |
| rxTick | output | 1 | Receive baud tick |
| txTick | output | 1 | Transmit baud tick |
| clkOut | output | 1 | Programmable clock output |

## Verification
The properties assume that configuration, counter and reload state change only through the block's own logic or a register write. Any cycle with wrEn high is therefore exempt from the hold checks. They also assume that the pins reach the counter only through the synchronizers. The stimulus changes the pins and port inputs only on falling clock edges. It holds each pin level for at least four cycles, so that every edge survives the two-flop synchronizer and is sampled on a tickEn cycle. It keeps tickEn high throughout, so that the counted periods in baud and clock-out modes are exact cycle counts.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int NB     = CNT_W / BYTE_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLDL = 3'd4;

  // control register, bit 7 down to bit 0
  typedef struct packed {
    logic txSel;
    logic rxSel;
    logic extFlag;
    logic ovfFlag;
    logic extEn;
    logic capSel;
    logic cntSel;
    logic run;
  } ctrl_t;

  // mode register, bit 1 down to bit 0
  typedef struct packed {
    logic clkOutEn;
    logic downEn;
  } mode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic inc;
    logic dec;
    logic loadRld;
    logic loadMax;
    logic capture;
    logic setOvf;
    logic setExt;
    logic togExt;
    logic togClk;
    logic rxPulse;
    logic txPulse;
  } strobe_t;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic pinIn,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], pinIn};
      if (tickEn) prevQ <= syncQ[STAGES-1];
    end
  end

  assign level = syncQ[STAGES-1];
  assign fall  = tickEn & prevQ & ~syncQ[STAGES-1];
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cntFall,
  input  logic             trigFall,
  input  logic             trigLevel,
  input  ctrl_t            ctrlQ,
  input  mode_t            modeQ,
  input  logic [CNT_W-1:0] cntQ,
  input  logic [CNT_W-1:0] rldQ,
  output strobe_t          stb
);
  logic baudMode, clkMode, capMode, udMode, plainMode;
  logic halfPhase, srcEvt, evt, goUp, atMax, atRld;
  logic wrapUp, wrapDn, extHit;

  always_comb begin
    baudMode  = ctrlQ.rxSel | ctrlQ.txSel;
    clkMode   = ~baudMode & modeQ.clkOutEn;
    capMode   = ~baudMode & ~clkMode & ctrlQ.capSel;
    udMode    = ~baudMode & ~clkMode & ~capMode & modeQ.downEn;
    plainMode = ~baudMode & ~clkMode & ~capMode & ~udMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              halfPhase <= 1'b0;
    else if (!clkMode)                      halfPhase <= 1'b0;
    else if (ctrlQ.run && tickEn)           halfPhase <= ~halfPhase;
  end

  always_comb begin
    srcEvt = ctrlQ.cntSel ? cntFall : tickEn;
    evt    = ctrlQ.run & (clkMode ? (tickEn & halfPhase) : srcEvt);
    goUp   = ~udMode | trigLevel;
    atMax  = &cntQ;
    atRld  = (cntQ == rldQ);
    wrapUp = evt & goUp & atMax;
    wrapDn = evt & ~goUp & atRld;
    extHit = ctrlQ.run & ctrlQ.extEn & trigFall & ~udMode;

    stb.loadRld = (wrapUp & ~capMode) | (extHit & plainMode);
    stb.loadMax = wrapDn;
    stb.inc     = evt & goUp & ~(atMax & ~capMode);
    stb.dec     = evt & ~goUp & ~atRld;
    stb.capture = extHit & capMode;
    stb.setOvf  = (wrapUp | wrapDn) & (capMode | udMode | plainMode);
    stb.setExt  = extHit;
    stb.togExt  = (wrapUp | wrapDn) & udMode;
    stb.togClk  = wrapUp & clkMode;
    stb.rxPulse = wrapUp & baudMode & ctrlQ.rxSel;
    stb.txPulse = wrapUp & baudMode & ctrlQ.txSel;
  end
endmodule

// File: rtl/tmr16_datapath.sv
module tmr16_datapath
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  input  strobe_t           stb,
  output ctrl_t             ctrlQ,
  output mode_t             modeQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic [CNT_W-1:0]  rldQ,
  output logic              clkOut,
  output logic              rxTick,
  output logic              txTick
);
  logic [NB-1:0]    cntLaneWr, rldLaneWr;
  logic [CNT_W-1:0] cntNext, rldNext;
  ctrl_t            ctrlNext;
  logic             ctrlWr, modeWr;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign cntLaneWr[g] = wrEn && (wrAddr == A_CNTL + ADDR_W'(g));
    assign rldLaneWr[g] = wrEn && (wrAddr == A_RLDL + ADDR_W'(g));
  end

  assign ctrlWr = wrEn && (wrAddr == A_CTRL);
  assign modeWr = wrEn && (wrAddr == A_MODE);

  always_comb begin
    cntNext = cntQ;
    if (|cntLaneWr) begin
      for (int i = 0; i < NB; i++)
        if (cntLaneWr[i]) cntNext[i*BYTE_W +: BYTE_W] = wrData;
    end else if (stb.loadRld) cntNext = rldQ;
    else if (stb.loadMax)     cntNext = '1;
    else if (stb.inc)         cntNext = cntQ + 1'b1;
    else if (stb.dec)         cntNext = cntQ - 1'b1;
  end

  always_comb begin
    rldNext = rldQ;
    if (|rldLaneWr) begin
      for (int i = 0; i < NB; i++)
        if (rldLaneWr[i]) rldNext[i*BYTE_W +: BYTE_W] = wrData;
    end else if (stb.capture) rldNext = cntQ;
  end

  always_comb begin
    ctrlNext = ctrlWr ? ctrl_t'(wrData) : ctrlQ;
    if (stb.togExt) ctrlNext.extFlag = ~ctrlNext.extFlag;
    if (stb.setExt) ctrlNext.extFlag = 1'b1;
    if (stb.setOvf) ctrlNext.ovfFlag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      rldQ   <= '0;
      ctrlQ  <= '0;
      modeQ  <= '0;
      clkOut <= 1'b0;
      rxTick <= 1'b0;
      txTick <= 1'b0;
    end else begin
      cntQ   <= cntNext;
      rldQ   <= rldNext;
      ctrlQ  <= ctrlNext;
      if (modeWr) modeQ <= mode_t'(wrData[1:0]);
      if (stb.togClk) clkOut <= ~clkOut;
      rxTick <= stb.rxPulse;
      txTick <= stb.txPulse;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == A_CTRL) rdData = ctrlQ;
    if (rdAddr == A_MODE) rdData = {{(BYTE_W-2){1'b0}}, modeQ};
    for (int i = 0; i < NB; i++) begin
      if (rdAddr == A_CNTL + ADDR_W'(i)) rdData = cntQ[i*BYTE_W +: BYTE_W];
      if (rdAddr == A_RLDL + ADDR_W'(i)) rdData = rldQ[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              ovfFlag,
  output logic              extFlag,
  output logic              rxTick,
  output logic              txTick,
  output logic              clkOut
);
  localparam int NPINS = 2;  // 0: count pin, 1: trigger pin

  logic [NPINS-1:0] pinVec, pinLevel, pinFall;
  strobe_t          stb;
  ctrl_t            ctrlQ;
  mode_t            modeQ;
  logic [CNT_W-1:0] cntQ, rldQ;

  assign pinVec = {trigPin, cntPin};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    tmr16_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rstN(rstN), .tickEn(tickEn), .pinIn(pinVec[g]),
      .level(pinLevel[g]), .fall(pinFall[g])
    );
  end

  tmr16_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .cntFall(pinFall[0]), .trigFall(pinFall[1]), .trigLevel(pinLevel[1]),
    .ctrlQ(ctrlQ), .modeQ(modeQ), .cntQ(cntQ), .rldQ(rldQ), .stb(stb)
  );

  tmr16_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .stb(stb), .ctrlQ(ctrlQ), .modeQ(modeQ),
    .cntQ(cntQ), .rldQ(rldQ), .clkOut(clkOut), .rxTick(rxTick), .txTick(txTick)
  );

  assign ovfFlag = ctrlQ.ovfFlag;
  assign extFlag = ctrlQ.extFlag;
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker
  import tmr16_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input ctrl_t            ctrlQ,
  input mode_t            modeQ,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] rldQ,
  input logic             rxTick,
  input logic             txTick,
  input logic             clkOut
);
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.run && !wrEn) |=> $stable(cntQ));

  p_rld_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.capSel && !wrEn) |=> $stable(rldQ));

  p_baud_no_ovf_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && (ctrlQ.rxSel || ctrlQ.txSel) && !ctrlQ.ovfFlag) |=> !ctrlQ.ovfFlag);

  p_rx_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxTick |-> $past(ctrlQ.rxSel));

  p_tx_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    txTick |-> $past(ctrlQ.txSel));

  p_clk_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !modeQ.clkOutEn) |=> $stable(clkOut));
endmodule

bind tmr16_top tmr16_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .ctrlQ(ctrlQ), .modeQ(modeQ),
  .cntQ(cntQ), .rldQ(rldQ), .rxTick(rxTick), .txTick(txTick), .clkOut(clkOut)
);

// File: tb/tmr16_top_bench.sv
module tmr16_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       cntPin = 1'b0;
  logic       trigPin = 1'b1;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       ovfFlag, extFlag, rxTick, txTick, clkOut;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];
  bit    monBusy = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tmr16_top u_tmr16_top (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntPin(cntPin), .trigPin(trigPin),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .ovfFlag(ovfFlag), .extFlag(extFlag), .rxTick(rxTick), .txTick(txTick), .clkOut(clkOut)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops expected register values and compares them at the read port
  initial begin
    forever begin
      item_t it;
      wait (sbq.size() > 0);
      monBusy = 1'b1;
      it = sbq.pop_front();
      @(negedge clk);
      rdAddr = it.addr;
      #5;
      check(rdData === it.exp, it.tag, {8'h00, rdData}, {8'h00, it.exp});
      monBusy = 1'b0;
    end
  end

  task automatic expectReg(input logic [2:0] addr, input logic [7:0] exp, input string tag);
    item_t it;
    it.addr = addr; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0 && !monBusy);
  endtask

  task automatic expect16(input logic [2:0] addrLo, input logic [15:0] exp, input string tag);
    expectReg(addrLo, exp[7:0], tag);
    expectReg(addrLo + 3'd1, exp[15:8], tag);
  endtask

  task automatic writeReg(input logic [2:0] addr, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic write16(input logic [2:0] addrLo, input logic [15:0] data);
    writeReg(addrLo, data[7:0]);
    writeReg(addrLo + 3'd1, data[15:8]);
  endtask

  task automatic pulseCnt();
    @(negedge clk) cntPin = 1'b1;
    repeat (4) @(negedge clk);
    cntPin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic setTrig(input logic v);
    @(negedge clk) trigPin = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int txCount;
    repeat (5) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 6; a++) expectReg(3'(a), 8'h00, "R1 register reset");
    check({ovfFlag, extFlag, rxTick, txTick, clkOut} === 5'b0, "R1 outputs reset",
          {11'b0, ovfFlag, extFlag, rxTick, txTick, clkOut}, 16'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3: counter mode, plain reload on overflow
    writeReg(3'd1, 8'h00);
    writeReg(3'd0, 8'h03);
    write16(3'd4, 16'hFFF0);
    write16(3'd2, 16'hFFFE);
    pulseCnt();
    expect16(3'd2, 16'hFFFF, "R2 count pin step");
    pulseCnt();
    expect16(3'd2, 16'hFFF0, "R3 reload on overflow");
    expectReg(3'd0, 8'h13, "R3 overflow flag set");
    check(ovfFlag === 1'b1, "R3 ovfFlag pin", {15'b0, ovfFlag}, 16'h1);

    // R9: software write clears flag
    writeReg(3'd0, 8'h03);
    expectReg(3'd0, 8'h03, "R9 flag cleared by write");
    expectReg(3'd1, 8'h00, "R9 mode readback");

    // R4: external reload
    writeReg(3'd0, 8'h0B);
    write16(3'd2, 16'h0100);
    write16(3'd4, 16'hABCD);
    setTrig(1'b0);
    expect16(3'd2, 16'hABCD, "R4 trigger reload");
    expectReg(3'd0, 8'h2B, "R4 ext flag set");
    setTrig(1'b1);
    writeReg(3'd0, 8'h03);
    write16(3'd2, 16'h0100);
    setTrig(1'b0);
    expect16(3'd2, 16'h0100, "R4 trigger ignored without enable");
    expectReg(3'd0, 8'h03, "R4 no ext flag without enable");
    setTrig(1'b1);

    // R5: capture
    writeReg(3'd0, 8'h0F);
    write16(3'd2, 16'h1234);
    write16(3'd4, 16'h0000);
    repeat (3) pulseCnt();
    setTrig(1'b0);
    expect16(3'd4, 16'h1237, "R5 capture value");
    expectReg(3'd0, 8'h2F, "R5 capture ext flag");
    expect16(3'd2, 16'h1237, "R5 counter unchanged by capture");
    setTrig(1'b1);
    write16(3'd2, 16'hFFFF);
    pulseCnt();
    expect16(3'd2, 16'h0000, "R5 capture-mode wrap to zero");
    expectReg(3'd0, 8'h3F, "R5 capture-mode overflow flag");
    expect16(3'd4, 16'h1237, "R5 reload register kept on wrap");

    // R2: run off freezes
    writeReg(3'd0, 8'h02);
    write16(3'd2, 16'h0042);
    repeat (2) pulseCnt();
    expect16(3'd2, 16'h0042, "R2 stopped counter holds");

    // R6: up/down
    writeReg(3'd0, 8'h0B);
    writeReg(3'd1, 8'h01);
    write16(3'd4, 16'h0005);
    write16(3'd2, 16'h0007);
    setTrig(1'b0);
    expect16(3'd2, 16'h0007, "R6 trigger edge does not reload");
    expectReg(3'd0, 8'h0B, "R6 trigger edge sets no flag");
    pulseCnt();
    expect16(3'd2, 16'h0006, "R6 down step");
    repeat (2) pulseCnt();
    expect16(3'd2, 16'hFFFF, "R6 underflow loads all ones");
    expectReg(3'd0, 8'h3B, "R6 underflow flags");
    setTrig(1'b1);
    pulseCnt();
    expect16(3'd2, 16'h0005, "R6 up overflow reloads");
    expectReg(3'd0, 8'h1B, "R6 ext flag toggled back");

    // R7: baud mode, capture select ignored
    writeReg(3'd0, 8'h00);
    writeReg(3'd1, 8'h00);
    write16(3'd4, 16'hFFFC);
    write16(3'd2, 16'hFFFC);
    writeReg(3'd0, 8'h45);
    do @(negedge clk); while (!rxTick);
    n = 0;
    do begin @(negedge clk); n++; end while (!rxTick);
    check(n == 4, "R7 rx tick period", 16'(n), 16'd4);
    txCount = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txTick) txCount++;
    end
    check(txCount == 0, "R7 tx tick unselected", 16'(txCount), 16'd0);
    expectReg(3'd0, 8'h45, "R7 no overflow flag in baud mode");
    writeReg(3'd0, 8'h00);

    // R8: clock-out
    writeReg(3'd1, 8'h02);
    write16(3'd4, 16'hFFFE);
    write16(3'd2, 16'hFFFE);
    writeReg(3'd0, 8'h01);
    do @(negedge clk); while (clkOut);
    do @(negedge clk); while (!clkOut);
    n = 0;
    do begin @(negedge clk); n++; end while (clkOut);
    do begin @(negedge clk); n++; end while (!clkOut);
    check(n == 8, "R8 clock-out period", 16'(n), 16'd8);
    expectReg(3'd0, 8'h01, "R8 no overflow flag in clock-out mode");
    writeReg(3'd0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule